// File: doc/BRIEF.md
# Four-Channel DMA Register and Counter Core

This block holds the processor-visible registers and the transfer counters of a four-channel DMA engine. A byte-wide port reaches, per channel, a 16-bit address register and a 16-bit count register. It also reaches a shared status register, a single-channel mask port, a mode port and a strobe that resets the byte pointer. The block has no external control or status registers beyond these.

Each 16-bit register is reached through two byte accesses that share one byte-pointer flip-flop. A side port loads an 8-bit page value per channel, and the page supplies the upper address bits. A per-channel step input marks one completed transfer. On each step the block advances the current address and retires one count. It flags terminal count and then either masks the channel or reloads it from its base copies.

The read data is combinational from the current state. Read side effects (byte-pointer toggle, status clear) take place at the clock edge that ends the read cycle.

Top module: `dmac_core`

## Requirements
- R1: After reset all four channels are masked, the byte pointer selects the low byte, and the status register reads 0x00.
- R2: Offsets reach the 16-bit registers as follows: 4·c is the address and 4·c+2 is the count of channel c. The first byte access after a pointer clear reaches bits [7:0] and the next reaches bits [15:8]. A write loads the base and current copies, and a read returns the current copy.
- R3: A write of any value to offset 0x18 returns the byte pointer to the low byte.
- R4: Reads of a 16-bit register toggle the byte pointer exactly as writes do.
- R5: The count is programmed as length minus one. Every step decrements the current count, and after the terminal step it reads back 0xFFFF.
- R6: Every step on an unmasked channel increments its 16-bit current address. The channel address output is {page, current address}, where the page is loaded through the page port.
- R7: The 16-bit current address wraps from 0xFFFF to 0x0000 without changing the page byte.
- R8: A write to offset 0x14 selects channel wdata[1:0]; wdata[2]=1 masks it and wdata[2]=0 unmasks it. A step on a masked channel changes nothing.
- R9: A step that finds the current count at 0 is the terminal step. It pulses tc_pulse for that channel and sets status bit c at offset 0x10. A read of the status register clears all its bits.
- R10: In single mode (mode bit 4 = 0), the terminal step sets the channel's mask bit.
- R11: In auto-initialize mode (mode bit 4 = 1), the terminal step reloads the current address and count from the base copies. The channel stays unmasked.
- R12: A write to offset 0x16 sets channel wdata[1:0]'s direction to wdata[3:2] and its auto-initialize flag to wdata[4].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| page_we | input | 1 | Page register write strobe |
| page_sel | input | 2 | Page register channel |
| page_wdata | input | 8 | Page value |
| step | input | 4 | One completed transfer per channel |
| ch_addr | output | 96 | Per channel {page, current address}; channel c at [24c+23:24c] |
| ch_dir | output | 8 | Per channel direction field, 2 bits each |
| ch_auto | output | 4 | Per channel auto-initialize flag |
| ch_masked | output | 4 | Per channel mask bit |
| tc_pulse | output | 4 | Terminal-step indication, same cycle as the step |

## Verification
Read data is combinational, so a read's expected byte is due in the cycle its strobe is high. The scoreboard pops it 2 ns after the falling edge that raised the strobe, before the edge that applies the pointer toggle or status clear. The effect of a write or step shows in the cycle after the rising edge that captures it. tc_pulse, however, is checked during the step cycle itself. The bench sets every input on a falling edge and samples after that edge, so each check falls in a known cycle.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
   localparam logic [4:0] OFS_STATUS = 5'h10;
   localparam logic [4:0] OFS_MASK   = 5'h14;
   localparam logic [4:0] OFS_MODE   = 5'h16;
   localparam logic [4:0] OFS_PTRCLR = 5'h18;

   localparam int MODE_AUTO_BIT = 4;
   localparam int MASK_SET_BIT  = 2;

   typedef enum logic [1:0] {
      DIR_CHECK    = 2'b00,
      DIR_TO_MEM   = 2'b01,
      DIR_FROM_MEM = 2'b10,
      DIR_RSVD     = 2'b11
   } dmac_dir_e;
endpackage

// File: rtl/dmac_chan.sv
module dmac_chan #(
   parameter int DW = 8,
   parameter int AW = 16,
   parameter int PW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_adr,
   input  logic          wr_cnt,
   input  logic          hi_byte,
   input  logic [DW-1:0] wdata,
   input  logic          step_ok,
   input  logic          auto_mode,
   input  logic          page_we,
   input  logic [PW-1:0] page_d,
   output logic [AW-1:0] cur_adr,
   output logic [AW-1:0] cur_cnt,
   output logic [PW-1:0] page_q,
   output logic          tc
);
   logic [AW-1:0] base_adr, base_cnt;
   logic          reload;

   generate
      if (AW != 2*DW) begin : g_bad_width
         $error("dmac_chan: AW must be twice DW");
      end
   endgenerate

   assign tc     = step_ok && (cur_cnt == '0);
   assign reload = tc && auto_mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_adr <= '0;
         cur_adr  <= '0;
      end else if (wr_adr) begin
         if (hi_byte) begin
            base_adr[AW-1:DW] <= wdata;
            cur_adr[AW-1:DW]  <= wdata;
         end else begin
            base_adr[DW-1:0] <= wdata;
            cur_adr[DW-1:0]  <= wdata;
         end
      end else if (step_ok) begin
         cur_adr <= reload ? base_adr : cur_adr + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_cnt <= '0;
         cur_cnt  <= '0;
      end else if (wr_cnt) begin
         if (hi_byte) begin
            base_cnt[AW-1:DW] <= wdata;
            cur_cnt[AW-1:DW]  <= wdata;
         end else begin
            base_cnt[DW-1:0] <= wdata;
            cur_cnt[DW-1:0]  <= wdata;
         end
      end else if (step_ok) begin
         cur_cnt <= reload ? base_cnt : cur_cnt - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       page_q <= '0;
      else if (page_we) page_q <= page_d;
   end
endmodule

// File: rtl/dmac_ctrl.sv
module dmac_ctrl #(
   parameter int NCH = 4,
   parameter int SW  = $clog2(NCH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc16,
   input  logic             ptr_clr,
   input  logic             mask_we,
   input  logic             mode_we,
   input  logic             stat_rd,
   input  logic [4:0]       cfg_d,
   input  logic [NCH-1:0]   tc,
   output logic             bptr,
   output logic [NCH-1:0]   mask,
   output logic [NCH-1:0]   status,
   output logic [2*NCH-1:0] dir,
   output logic [NCH-1:0]   auto_q
);
   import dmac_pkg::*;

   logic [SW-1:0] cfg_ch;
   assign cfg_ch = cfg_d[SW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       bptr <= 1'b0;
      else if (ptr_clr) bptr <= 1'b0;
      else if (acc16)   bptr <= ~bptr;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status <= '0;
      else        status <= (stat_rd ? '0 : status) | tc;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask   <= '1;
         dir    <= '0;
         auto_q <= '0;
      end else begin
         for (int c = 0; c < NCH; c++) begin
            if (mask_we && cfg_ch == SW'(c)) mask[c] <= cfg_d[MASK_SET_BIT];
            if (tc[c] && !auto_q[c])         mask[c] <= 1'b1;
            if (mode_we && cfg_ch == SW'(c)) begin
               dir[2*c +: 2] <= cfg_d[3:2];
               auto_q[c]     <= cfg_d[MODE_AUTO_BIT];
            end
         end
      end
   end
endmodule

// File: rtl/dmac_core.sv
module dmac_core #(
   parameter int NCH = 4,
   parameter int DW  = 8,
   parameter int AW  = 16,
   parameter int PW  = 8,
   parameter int OW  = 5,
   localparam int SW  = $clog2(NCH),
   localparam int APW = AW + PW
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             rd_en,
   input  logic [OW-1:0]    addr,
   input  logic [DW-1:0]    wdata,
   output logic [DW-1:0]    rdata,
   input  logic             page_we,
   input  logic [SW-1:0]    page_sel,
   input  logic [PW-1:0]    page_wdata,
   input  logic [NCH-1:0]   step,
   output logic [NCH*APW-1:0] ch_addr,
   output logic [2*NCH-1:0] ch_dir,
   output logic [NCH-1:0]   ch_auto,
   output logic [NCH-1:0]   ch_masked,
   output logic [NCH-1:0]   tc_pulse
);
   import dmac_pkg::*;

   generate
      if (NCH != 4 || OW != 5) begin : g_bad_map
         $error("dmac_core: register map needs NCH=4 and OW=5");
      end
      if (DW < 5 || DW < NCH) begin : g_bad_dw
         $error("dmac_core: DW too narrow for control fields");
      end
   endgenerate

   logic          reg16, acc16, wr16, bptr;
   logic [SW-1:0] sel;
   logic [NCH-1:0] status, step_ok;
   logic [AW-1:0] cur_adr [NCH];
   logic [AW-1:0] cur_cnt [NCH];
   logic [AW-1:0] word;

   assign reg16   = (addr[OW-1] == 1'b0) && (addr[0] == 1'b0);
   assign acc16   = (wr_en || rd_en) && reg16;
   assign wr16    = wr_en && reg16;
   assign sel     = addr[SW+1:2];
   assign step_ok = step & ~ch_masked;

   dmac_ctrl #(.NCH(NCH)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .acc16   (acc16),
      .ptr_clr (wr_en && addr == OFS_PTRCLR),
      .mask_we (wr_en && addr == OFS_MASK),
      .mode_we (wr_en && addr == OFS_MODE),
      .stat_rd (rd_en && addr == OFS_STATUS),
      .cfg_d   (wdata[4:0]),
      .tc      (tc_pulse),
      .bptr    (bptr),
      .mask    (ch_masked),
      .status  (status),
      .dir     (ch_dir),
      .auto_q  (ch_auto)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic [PW-1:0] page_q;
      dmac_chan #(.DW(DW), .AW(AW), .PW(PW)) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_adr    (wr16 && sel == SW'(c) && !addr[1]),
         .wr_cnt    (wr16 && sel == SW'(c) &&  addr[1]),
         .hi_byte   (bptr),
         .wdata     (wdata),
         .step_ok   (step_ok[c]),
         .auto_mode (ch_auto[c]),
         .page_we   (page_we && page_sel == SW'(c)),
         .page_d    (page_wdata),
         .cur_adr   (cur_adr[c]),
         .cur_cnt   (cur_cnt[c]),
         .page_q    (page_q),
         .tc        (tc_pulse[c])
      );
      assign ch_addr[c*APW +: APW] = {page_q, cur_adr[c]};
   end

   assign word = addr[1] ? cur_cnt[sel] : cur_adr[sel];

   always_comb begin
      rdata = '0;
      if (reg16)                   rdata = bptr ? word[AW-1:DW] : word[DW-1:0];
      else if (addr == OFS_STATUS) rdata = {{(DW-NCH){1'b0}}, status};
   end
endmodule

// File: rtl/dmac_core_chk.sv
module dmac_core_chk #(
   parameter int NCH = 4,
   parameter int AW  = 16,
   parameter int PW  = 8,
   localparam int APW = AW + PW
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_en,
   input logic               page_we,
   input logic [NCH-1:0]     step,
   input logic [NCH*APW-1:0] ch_addr,
   input logic [NCH-1:0]     ch_auto,
   input logic [NCH-1:0]     ch_masked,
   input logic [NCH-1:0]     tc_pulse
);
   for (genvar c = 0; c < NCH; c++) begin : g_a
      AST_TC_ON_LIVE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
         tc_pulse[c] |-> (step[c] && !ch_masked[c])); // R9
      AST_SINGLE_TC_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
         (tc_pulse[c] && !ch_auto[c]) |=> ch_masked[c]); // R10
      AST_AUTO_STAYS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
         (tc_pulse[c] && ch_auto[c] && !wr_en) |=> !ch_masked[c]); // R11
      AST_MASKED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
         (ch_masked[c] && !wr_en && !page_we) |=> $stable(ch_addr[c*APW +: APW])); // R8
      AST_PAGE_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
         !page_we |=> $stable(ch_addr[c*APW+AW +: PW])); // R7
   end
endmodule

bind dmac_core dmac_core_chk #(.NCH(NCH), .AW(AW), .PW(PW)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .page_we   (page_we),
   .step      (step),
   .ch_addr   (ch_addr),
   .ch_auto   (ch_auto),
   .ch_masked (ch_masked),
   .tc_pulse  (tc_pulse)
);

// File: tb/test_dmac_core.sv
module test_dmac_core;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0, page_we = 1'b0;
   logic [4:0]  addr = '0;
   logic [7:0]  wdata = '0, page_wdata = '0;
   logic [1:0]  page_sel = '0;
   logic [3:0]  step = '0;
   logic [7:0]  rdata;
   logic [95:0] ch_addr;
   logic [7:0]  ch_dir;
   logic [3:0]  ch_auto, ch_masked, tc_pulse;

   int checks = 0, errors = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #5 clk = ~clk;

   dmac_core i_dmac_core (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .page_we(page_we), .page_sel(page_sel),
      .page_wdata(page_wdata), .step(step), .ch_addr(ch_addr), .ch_dir(ch_dir),
      .ch_auto(ch_auto), .ch_masked(ch_masked), .tc_pulse(tc_pulse)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      #1;
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [7:0] d);
      @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, input logic [7:0] e, input string tag);
      exp_q.push_back(e); tag_q.push_back(tag);
      @(negedge clk); rd_en = 1'b1; addr = a;
      @(negedge clk); rd_en = 1'b0;
   endtask

   task automatic pg(input logic [1:0] c, input logic [7:0] d);
      @(negedge clk); page_we = 1'b1; page_sel = c; page_wdata = d;
      @(negedge clk); page_we = 1'b0;
   endtask

   task automatic stp(input logic [3:0] m, input logic [3:0] exp_tc, input string tag);
      @(negedge clk); step = m;
      #2; checks++;
      if (tc_pulse !== exp_tc) begin
         errors++;
         $display("FAIL %s: tc_pulse actual %0h expected %0h", tag, tc_pulse, exp_tc);
      end
      @(negedge clk); step = '0;
   endtask

   // monitor: compares read data in the cycle the read strobe is high
   always begin
      @(negedge clk); #2;
      if (rd_en) begin
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL scoreboard: unexpected read, actual %0h expected none", rdata);
         end else begin
            automatic logic [7:0] e = exp_q.pop_front();
            automatic string      t = tag_q.pop_front();
            if (rdata !== e) begin
               errors++;
               $display("FAIL %s: rdata actual %0h expected %0h", t, rdata, e);
            end
         end
      end
   end

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1 mask", ch_masked, 4'hF);
      rd(5'h10, 8'h00, "R1 status");
      wr(5'h00, 8'hAB);
      chk("R1 pointer low", ch_addr[23:0], 24'h0000AB);
      // R2 byte order and readback
      wr(5'h18, 8'h00);
      wr(5'h04, 8'h34); wr(5'h04, 8'h12);
      chk("R2 ch1 word", ch_addr[47:24], 24'h001234);
      rd(5'h04, 8'h34, "R2 low"); rd(5'h04, 8'h12, "R2 high");
      // R3 pointer clear
      wr(5'h04, 8'h77); wr(5'h18, 8'h5C); wr(5'h04, 8'h56);
      chk("R3 clear", ch_addr[47:24], 24'h001256);
      // R4 read toggles pointer
      wr(5'h18, 8'h00);
      rd(5'h04, 8'h56, "R4 low");
      wr(5'h04, 8'h99);
      chk("R4 write after read hits high", ch_addr[47:24], 24'h009956);
      // R6 R12 R8 R5 R9 R10 on channel 2, single mode
      pg(2'd2, 8'h5A);
      wr(5'h18, 8'h00);
      wr(5'h08, 8'h00); wr(5'h08, 8'h10);
      wr(5'h0A, 8'h02); wr(5'h0A, 8'h00);
      wr(5'h16, 8'h06);
      chk("R12 dir ch2", ch_dir[5:4], 2'b01);
      chk("R12 auto ch2", ch_auto[2], 1'b0);
      stp(4'h4, 4'h0, "R8 masked step");
      chk("R8 masked no move", ch_addr[71:48], 24'h5A1000);
      wr(5'h14, 8'h02);
      chk("R8 unmask", ch_masked[2], 1'b0);
      stp(4'h4, 4'h0, "R6 step");
      chk("R6 addr+page", ch_addr[71:48], 24'h5A1001);
      rd(5'h0A, 8'h01, "R5 count low"); rd(5'h0A, 8'h00, "R5 count high");
      stp(4'h4, 4'h0, "R5 last count");
      stp(4'h4, 4'h4, "R9 tc pulse");
      chk("R10 auto mask", ch_masked[2], 1'b1);
      chk("R6 addr after tc", ch_addr[71:48], 24'h5A1003);
      rd(5'h0A, 8'hFF, "R5 ffff low"); rd(5'h0A, 8'hFF, "R5 ffff high");
      rd(5'h10, 8'h04, "R9 status set"); rd(5'h10, 8'h00, "R9 status cleared");
      stp(4'h4, 4'h0, "R10 masked after tc");
      chk("R10 frozen", ch_addr[71:48], 24'h5A1003);
      // R7 wrap on channel 3
      pg(2'd3, 8'h33);
      wr(5'h0C, 8'hFF); wr(5'h0C, 8'hFF);
      wr(5'h0E, 8'h05); wr(5'h0E, 8'h00);
      wr(5'h16, 8'h03); wr(5'h14, 8'h03);
      stp(4'h8, 4'h0, "R7 step");
      chk("R7 wrap keeps page", ch_addr[95:72], 24'h330000);
      // R11 auto-init on channel 0
      wr(5'h00, 8'h00); wr(5'h00, 8'h02);
      wr(5'h02, 8'h01); wr(5'h02, 8'h00);
      wr(5'h16, 8'h18);
      chk("R12 dir ch0", ch_dir[1:0], 2'b10);
      chk("R12 auto ch0", ch_auto[0], 1'b1);
      wr(5'h14, 8'h00);
      stp(4'h1, 4'h0, "R11 step1");
      chk("R11 addr", ch_addr[23:0], 24'h000201);
      stp(4'h1, 4'h1, "R11 tc");
      chk("R11 reload addr", ch_addr[23:0], 24'h000200);
      chk("R11 stays unmasked", ch_masked[0], 1'b0);
      rd(5'h02, 8'h01, "R11 reload count low"); rd(5'h02, 8'h00, "R11 reload count high");
      rd(5'h10, 8'h01, "R9 status ch0");
      wr(5'h14, 8'h04);
      chk("R8 remask", ch_masked[0], 1'b1);
      stp(4'h1, 4'h0, "R8 remasked step");
      chk("R8 remasked frozen", ch_addr[23:0], 24'h000200);
      repeat (3) @(negedge clk);
      chk("scoreboard drained", exp_q.size(), 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule